// File: doc/BRIEF.md
# SPI Master Byte Shift Engine

This block moves one byte at a time over a four-wire SPI bus as the only master, using clock mode 0. The host places a byte in a one-entry transmit holding register. The engine moves that byte into its shift register and sends it most significant bit first on `mosi`. At the same time it collects eight bits from `miso`. When the eighth bit has been sampled, the received byte appears on `rd_data` and a sticky completion flag is raised. That flag can also drive an interrupt request.

The serial clock is derived from the system clock. Each half-period of `sclk` lasts `div_val + 1` system clocks, so a target rate f is reached with `div_val = f_sys / (2 f) - 1`. The holding register lets the host queue the next byte while the current one is still shifting. The `txe` output tells the host when a byte may be written. A write while the holding register is occupied is dropped and raises a sticky collision flag. The chip-select line follows a host control bit directly.

Top module: `spi_byte_master`

## Requirements
- R1: Synchronous active-high reset leaves `sclk`=0, `mosi`=0, `cs_n`=1, `done`=0, `coll`=0, `irq`=0, `txe`=1 and `rd_data`=0x00.
- R2: Mode 0 framing. `sclk` idles low and its first edge in each bit is rising. `mosi` carries the transmit byte MSB first and is valid before each rising edge. `mosi` is 0 while no byte is shifting.
- R3: Each `sclk` half-period lasts `div_val`+1 system clocks (D). The first rising edge of a byte appears D+1 clocks after the clock edge that accepted the write.
- R4: The received byte is captured MSB first from `miso` on the `sclk` rising edges. The clock edge that makes the 8th rising edge, 1+15·D clocks after the accepting edge, puts the byte on `rd_data` and sets `done`. `sclk` returns low D clocks later.
- R5: `done` stays set until `clr_done` is pulsed with no transfer completing; it then reads 0 after the next clock edge.
- R6: `irq` is 1 exactly while `done`=1 and `irq_en`=1.
- R7: A write (`wr_en`=1) made while `txe`=1 is stored, and `txe` reads 0 after that edge. `txe` returns to 1 on the next clock edge at which the engine takes the byte into its shift register.
- R8: A write made while `txe`=0 sets `coll` after that edge, and the written byte is discarded: it is never sent. `coll` stays set until `clr_coll` is pulsed.
- R9: A byte waiting in the holding register when a transfer's last falling edge occurs starts at that same edge. Its completion is therefore exactly 16·D clocks after the previous one, with no idle gap.
- R10: `cs_n` equals the inverse of `cs_sel` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_val | input | DIV_W | Half-period length minus one, in system clocks |
| irq_en | input | 1 | Lets `done` drive `irq` |
| cs_sel | input | 1 | 1 selects the slave (drives `cs_n` low) |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Transmit byte |
| clr_done | input | 1 | Clears the completion flag |
| clr_coll | input | 1 | Clears the collision flag |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Slave select, active low |
| rd_data | output | 8 | Last received byte |
| done | output | 1 | Sticky completion flag |
| coll | output | 1 | Sticky write-collision flag |
| txe | output | 1 | Transmit holding register empty |
| irq | output | 1 | Interrupt request |

## Verification
Every result has a fixed latency counted from the clock edge that accepts a write, with D = `div_val`+1. `txe` falls after that edge and rises one edge later. `sclk` first rises after edge D+1. `done` and `rd_data` change after edge 1+15·D, and `sclk` falls back low after edge 1+16·D. A queued second byte completes after edge 1+31·D. The bench keeps a free-running edge counter and waits to the exact edge number before it samples, one time unit after the edge. It checks the cycle just before each result as well, so early or late outputs are both caught. A behavioural slave on the bench side drives `miso` and records `mosi`, which makes the bit order visible at the pins.

// File: rtl/spi_pkg.sv
package spi_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0]    byte_t;
    typedef logic [BIT_IDX_W-1:0] bit_idx_t;

    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;

    typedef struct packed {
        eng_state_e state;
        logic       sclk;
        bit_idx_t   bit_idx;
        byte_t      sh_out;
        byte_t      sh_in;
    } eng_regs_t;

    localparam bit_idx_t LAST_BIT = bit_idx_t'(BYTE_W - 1);

    function automatic byte_t push_bit(byte_t cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div_val);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_tx_buf.sv
module spi_tx_buf
    import spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  take,
    input  logic  clr_coll,
    output byte_t buf_data,
    output logic  buf_full,
    output logic  coll
);
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_data <= '0;
            buf_full <= 1'b0;
        end else if (wr_en && !buf_full) begin
            buf_data <= wr_data;
            buf_full <= 1'b1;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coll <= 1'b0;
        end else if (wr_en && buf_full) begin
            coll <= 1'b1;
        end else if (clr_coll) begin
            coll <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  buf_full,
    input  byte_t buf_data,
    input  logic  miso,
    output logic  take,
    output logic  run,
    output logic  sclk,
    output logic  mosi,
    output byte_t rd_data,
    output logic  byte_done
);
    eng_regs_t r_q;
    logic      last_bit;
    logic      rise_now;
    logic      fall_now;

    assign run      = (r_q.state == ENG_SHIFT);
    assign last_bit = (r_q.bit_idx == LAST_BIT);
    assign rise_now = run && tick && !r_q.sclk;
    assign fall_now = run && tick && r_q.sclk;

    assign take      = ((r_q.state == ENG_IDLE) && buf_full) ||
                       (fall_now && last_bit && buf_full);
    assign byte_done = rise_now && last_bit;
    assign sclk      = r_q.sclk;
    assign mosi      = run && r_q.sh_out[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '{state: ENG_IDLE, sclk: 1'b0, bit_idx: '0,
                         sh_out: '0, sh_in: '0};
            rd_data <= '0;
        end else if (r_q.state == ENG_IDLE) begin
            if (buf_full) begin
                r_q.state   <= ENG_SHIFT;
                r_q.sclk    <= 1'b0;
                r_q.bit_idx <= '0;
                r_q.sh_out  <= buf_data;
            end
        end else if (rise_now) begin
            r_q.sclk  <= 1'b1;
            r_q.sh_in <= push_bit(r_q.sh_in, miso);
            if (last_bit) begin
                rd_data <= push_bit(r_q.sh_in, miso);
            end
        end else if (fall_now) begin
            r_q.sclk <= 1'b0;
            if (!last_bit) begin
                r_q.bit_idx <= r_q.bit_idx + 1'b1;
                r_q.sh_out  <= push_bit(r_q.sh_out, 1'b0);
            end else if (buf_full) begin
                r_q.bit_idx <= '0;
                r_q.sh_out  <= buf_data;
            end else begin
                r_q.state <= ENG_IDLE;
            end
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             irq_en,
    input  logic             cs_sel,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             clr_done,
    input  logic             clr_coll,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             coll,
    output logic             txe,
    output logic             irq
);
    logic  tick;
    logic  run;
    logic  take;
    logic  buf_full;
    byte_t buf_data;
    logic  byte_done;
    logic  done_q;
    logic  cs_n_q;

    spi_clk_div #(.DIV_W(DIV_W)) div_i (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_val (div_val),
        .tick    (tick)
    );

    spi_tx_buf buf_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .clr_coll (clr_coll),
        .buf_data (buf_data),
        .buf_full (buf_full),
        .coll     (coll)
    );

    spi_shifter shf_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .buf_full  (buf_full),
        .buf_data  (buf_data),
        .miso      (miso),
        .take      (take),
        .run       (run),
        .sclk      (sclk),
        .mosi      (mosi),
        .rd_data   (rd_data),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else if (byte_done) begin
            done_q <= 1'b1;
        end else if (clr_done) begin
            done_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= !cs_sel;
        end
    end

    assign done = done_q;
    assign cs_n = cs_n_q;
    assign txe  = !buf_full;
    assign irq  = done_q && irq_en;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic txe,
    input logic coll,
    input logic clr_coll,
    input logic done,
    input logic clr_done,
    input logic sclk,
    input logic cs_sel,
    input logic cs_n
);
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && txe) |=> !txe);                                    // R7

    AST_FULL_WRITE_COLLIDES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !txe) |=> coll);                                   // R8

    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (coll && !clr_coll) |=> coll);                               // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_done) |=> done);                               // R5

    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $rose(sclk));                                // R4

    AST_CS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        cs_sel |=> !cs_n);                                           // R10
endmodule

bind spi_byte_master spi_byte_master_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .txe      (txe),
    .coll     (coll),
    .clr_coll (clr_coll),
    .done     (done),
    .clr_done (clr_done),
    .sclk     (sclk),
    .cs_sel   (cs_sel),
    .cs_n     (cs_n)
);

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_val = '0;
    logic       irq_en = 1'b0;
    logic       cs_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       clr_done = 1'b0;
    logic       clr_coll = 1'b0;
    logic       miso;
    logic       sclk, mosi, cs_n, done, coll, txe, irq;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // bench-side slave
    logic [15:0] s_pat = '0;
    int          s_base = 0;
    int          s_falls = 0;
    logic [15:0] s_rx = '0;
    int          s_idx;

    always #2 clk = !clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge sclk) s_falls <= s_falls + 1;
    always @(posedge sclk) s_rx <= {s_rx[14:0], mosi};

    assign s_idx = s_falls - s_base;
    assign miso  = (s_idx >= 0 && s_idx < 16) ? s_pat[15 - s_idx] : 1'b0;

    spi_byte_master dut_i (
        .clk      (clk),
        .rst      (rst),
        .div_val  (div_val),
        .irq_en   (irq_en),
        .cs_sel   (cs_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .clr_done (clr_done),
        .clr_coll (clr_coll),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .cs_n     (cs_n),
        .rd_data  (rd_data),
        .done     (done),
        .coll     (coll),
        .txe      (txe),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // advance to just after clock edge number t
    task automatic wait_to(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    // one clock edge with given write/clear strobes, sampled 1 unit after
    task automatic step(input logic we, input logic [7:0] wd,
                        input logic cd, input logic cc);
        @(negedge clk);
        wr_en = we; wr_data = wd; clr_done = cd; clr_coll = cc;
        @(posedge clk);
        #1;
        wr_en = 1'b0; clr_done = 1'b0; clr_coll = 1'b0;
    endtask

    // vectors: {div_val, tx byte, slave byte, irq_en}
    localparam int NV = 5;
    localparam logic [24:0] VEC [NV] = '{
        {8'd0, 8'hA5, 8'h3C, 1'b1},
        {8'd1, 8'h81, 8'h7E, 1'b0},
        {8'd3, 8'h00, 8'hFF, 1'b1},
        {8'd2, 8'hFF, 8'h00, 1'b0},
        {8'd4, 8'h5A, 8'hC3, 1'b1}
    };

    initial begin : watchdog
        wait (cyc > 150000);
        bad++;
        $display("FAIL watchdog act=%0d exp<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int e0;
        int d;
        logic [7:0] tx, sl;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        chk("R1 sclk", sclk, 0);
        chk("R1 mosi", mosi, 0);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 done", done, 0);
        chk("R1 coll", coll, 0);
        chk("R1 irq", irq, 0);
        chk("R1 txe", txe, 1);
        chk("R1 rd_data", rd_data, 8'h00);

        // R10 chip select follows the control bit one edge later
        @(negedge clk);
        cs_sel = 1'b1;
        chk("R10 cs_n before edge", cs_n, 1);
        @(posedge clk);
        #1;
        chk("R10 cs_n asserted", cs_n, 0);

        // vector walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            div_val = VEC[i][24:17];
            tx      = VEC[i][16:9];
            sl      = VEC[i][8:1];
            irq_en  = VEC[i][0];
            d       = int'(div_val) + 1;
            s_pat   = {sl, 8'h00};
            s_base  = s_falls;
            step(1'b0, 8'h00, 1'b1, 1'b0);
            chk("R5 done cleared", done, 0);
            step(1'b1, tx, 1'b0, 1'b0);
            e0 = cyc;
            chk("R7 txe low after write", txe, 0);
            wait_to(e0 + d);
            chk("R3 sclk low before first rise", sclk, 0);
            chk("R7 txe back after take", txe, 1);
            wait_to(e0 + d + 1);
            chk("R3 sclk first rise", sclk, 1);
            chk("R2 mosi msb first", mosi, tx[7]);
            wait_to(e0 + 15 * d);
            chk("R4 done not early", done, 0);
            wait_to(e0 + 15 * d + 1);
            chk("R4 done set", done, 1);
            chk("R4 rd_data", rd_data, sl);
            chk("R6 irq", irq, irq_en);
            wait_to(e0 + 16 * d);
            chk("R4 sclk still high", sclk, 1);
            chk("R5 done sticky", done, 1);
            wait_to(e0 + 16 * d + 1);
            chk("R2 sclk idles low", sclk, 0);
            chk("R2 mosi idle low", mosi, 0);
            chk("R2 slave got tx byte", s_rx[7:0], tx);
        end

        // R6 irq gated by enable, R5 clear
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        chk("R6 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R6 irq enabled", irq, 1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk("R5 done cleared by host", done, 0);
        chk("R6 irq drops with done", irq, 0);

        // R8 R9 collision and back-to-back, D = 1
        @(negedge clk);
        div_val = 8'd0;
        s_pat   = {8'h96, 8'h4B};
        s_base  = s_falls;
        step(1'b1, 8'hA5, 1'b0, 1'b0);
        e0 = cyc;
        step(1'b1, 8'h11, 1'b0, 1'b0);
        chk("R8 coll on full write", coll, 1);
        step(1'b1, 8'h3C, 1'b0, 1'b1);
        chk("R8 coll cleared", coll, 0);
        chk("R7 txe low with queued byte", txe, 0);
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        chk("R8 coll again", coll, 1);
        wait_to(e0 + 16);
        chk("R9 first done", done, 1);
        chk("R9 first rd_data", rd_data, 8'h96);
        chk("R8 coll sticky", coll, 1);
        wait_to(e0 + 17);
        chk("R9 no idle gap", sclk, 0);
        chk("R9 next mosi bit", mosi, 1'b0);
        wait_to(e0 + 31);
        chk("R9 rd_data before second", rd_data, 8'h96);
        wait_to(e0 + 32);
        chk("R9 second rd_data", rd_data, 8'h4B);
        wait_to(e0 + 33);
        chk("R9 sclk low at end", sclk, 0);
        chk("R9 slave got both", s_rx, 16'hA53C);
        chk("R7 txe empty at end", txe, 1);
        wait_to(e0 + 80);
        chk("R8 discarded byte not sent", sclk, 0);
        chk("R8 slave unchanged", s_rx, 16'hA53C);

        // R10 deselect
        @(negedge clk);
        cs_sel = 1'b0;
        @(posedge clk);
        #1;
        chk("R10 cs_n released", cs_n, 1);

        // R1 reset mid-transfer
        step(1'b1, 8'h77, 1'b0, 1'b0);
        wait_to(cyc + 5);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R1 sclk after reset", sclk, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 coll after reset", coll, 0);
        chk("R1 txe after reset", txe, 1);
        chk("R1 cs_n after reset", cs_n, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule